// File: doc/BRIEF.md
# Split-Mode Internal Data Memory

This block is the on-chip data store of an 8-bit microcontroller core. An 8-bit address reaches 384 byte locations, because the upper half of the address range means different things in different access modes. A direct access to the upper half goes out on a special-function-register (SFR) request port. An indirect access to the same addresses reaches a second 128-byte RAM. The lower half is the same RAM in both modes.

On top of byte access, the block offers two more modes. A register mode resolves a 3-bit register number against a 2-bit bank select, so that swapping the whole working register set costs one bank-select change instead of a save and restore. A bit mode sets, clears or tests single flags. Bit writes are done internally as a read-modify-write of the byte that holds the flag, and the requester sees one access.

Requests take one cycle. Read data is registered and comes back one cycle later. SFR accesses pass through to the port in the same cycle, and the SFR side answers combinationally. Stack pointers live in the core and use indirect mode, so a stack may grow into the upper RAM.

Top module: `idata_mem`

## Requirements
- R1: In direct mode (mode 2'b00) and indirect mode (mode 2'b01), addresses 0x00–0x7F reach the same RAM bytes. A byte written in one mode reads back unchanged in the other.
- R2: A direct access to 0x80–0xFF raises sfr_req with sfr_addr equal to the address and does not touch RAM. A direct write drives sfr_wr with sfr_wdata equal to wdata. A direct read returns the sfr_rdata of the request cycle.
- R3: An indirect access to 0x80–0xFF reaches a separate 128-byte RAM that is independent of both the SFR port and the lower 128 bytes. It never raises sfr_req.
- R4: Register mode (mode 2'b11) takes the register number from addr[2:0] and the bank from bank_sel. It reaches RAM byte bank_sel*8 + addr[2:0], the same byte that a direct access to that address reaches.
- R5: In bit mode (mode 2'b10), a bit address below 0x80 selects byte 0x20 + addr[6:3], bit addr[2:0]. A bit write sets that bit to wdata[0] and leaves the other seven bits of the byte unchanged.
- R6: A bit-mode read returns the selected bit in rdata[0], with rdata[7:1] equal to zero.
- R7: A bit address of 0x80 or above goes to the SFR port with sfr_addr = {addr[7:3], 3'b000}. A bit write drives sfr_wdata equal to sfr_rdata with only bit addr[2:0] replaced by wdata[0], in the same cycle as the request.
- R8: The cycle after a read request (req=1, wr=0), rvalid is 1 and rdata holds the result. In any other cycle, rvalid is 0. Reset clears rvalid and rdata to zero.
- R9: While req is 0, the memory does not change whatever wr, addr and wdata hold, and sfr_req and sfr_wr stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request for this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| mode | input | 2 | 00 direct, 01 indirect, 10 bit, 11 register |
| addr | input | 8 | Byte address, bit address or register number |
| bank_sel | input | 2 | Active register bank |
| wdata | input | 8 | Write byte; bit writes use bit 0 |
| rdata | output | 8 | Registered read result |
| rvalid | output | 1 | rdata holds a new result |
| sfr_req | output | 1 | SFR access request |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR byte address |
| sfr_wdata | output | 8 | SFR write byte |
| sfr_rdata | input | 8 | SFR read byte, combinational reply |

## Verification
If the route decoder is wrong, the damage shows up at the ports. A wrong half-select or bank offset makes a byte written in one mode read back wrong in another mode, one cycle after the read request. If the bit-merge is wrong, a neighbouring flag changes, and the next byte read of 0x20–0x2F shows it. An SFR merge that is wrong shows up in the SFR model at the very next clock edge. Sweeping every address in every mode exposes each of these faults within a few hundred accesses.

// File: rtl/idata_pkg.sv
package idata_pkg;

    localparam int AW      = 8;
    localparam int DW      = 8;
    localparam int HALF_SZ = 1 << (AW - 1);
    localparam int IDX_W   = AW - 1;
    localparam int POS_W   = $clog2(DW);

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'b00,
        AM_INDIRECT = 2'b01,
        AM_BIT      = 2'b10,
        AM_REG      = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        TGT_LOW  = 2'd0,
        TGT_HIGH = 2'd1,
        TGT_SFR  = 2'd2
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    sfr_addr;
        logic             is_bit;
        logic [POS_W-1:0] pos;
    } route_t;

    function automatic logic [DW-1:0] merge_bit(input logic [DW-1:0] b,
                                                 input logic [POS_W-1:0] p,
                                                 input logic v);
        logic [DW-1:0] r;
        r    = b;
        r[p] = v;
        return r;
    endfunction

endpackage

// File: rtl/idata_route.sv
module idata_route
    import idata_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int BIT_BASE      = 32
) (
    input  logic [1:0]                     mode,
    input  logic [AW-1:0]                  addr,
    input  logic [$clog2(NUM_BANKS)-1:0]   bank_sel,
    output route_t                         route
);
    localparam int RW = $clog2(REGS_PER_BANK);
    localparam int BW = $clog2(NUM_BANKS);
    localparam logic [IDX_W-1:0] BASE = IDX_W'(BIT_BASE);

    amode_e am;
    assign am = amode_e'(mode);

    always_comb begin
        route          = '0;
        route.tgt      = TGT_LOW;
        route.idx      = addr[IDX_W-1:0];
        route.sfr_addr = addr;
        route.pos      = addr[POS_W-1:0];
        unique case (am)
            AM_DIRECT: begin
                route.tgt = addr[AW-1] ? TGT_SFR : TGT_LOW;
            end
            AM_INDIRECT: begin
                route.tgt = addr[AW-1] ? TGT_HIGH : TGT_LOW;
            end
            AM_BIT: begin
                route.is_bit = 1'b1;
                if (addr[AW-1]) begin
                    route.tgt      = TGT_SFR;
                    route.sfr_addr = {addr[AW-1:POS_W], {POS_W{1'b0}}};
                end else begin
                    route.tgt = TGT_LOW;
                    route.idx = BASE + IDX_W'(addr[AW-2:POS_W]);
                end
            end
            AM_REG: begin
                route.tgt = TGT_LOW;
                route.idx = '0;
                route.idx[BW+RW-1:0] = {bank_sel, addr[RW-1:0]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/idata_store.sv
module idata_store
    import idata_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic             sel_hi,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wbyte,
    output logic [DW-1:0]    rbyte
);
    localparam int NHALF = 2;

    logic [DW-1:0] rd [NHALF];

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic [DW-1:0] mem [HALF_SZ];
        always_ff @(posedge clk) begin
            if (we && (sel_hi == 1'(h)))
                mem[idx] <= wbyte;
        end
        assign rd[h] = mem[idx];
    end

    assign rbyte = rd[sel_hi];

endmodule

// File: rtl/idata_bitops.sv
module idata_bitops
    import idata_pkg::*;
(
    input  route_t        route,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cur,
    output logic [DW-1:0] wbyte,
    output logic [DW-1:0] rfmt
);
    always_comb begin
        if (route.is_bit) begin
            wbyte = merge_bit(cur, route.pos, wdata[0]);
            rfmt  = DW'(cur[route.pos]);
        end else begin
            wbyte = wdata;
            rfmt  = cur;
        end
    end

endmodule

// File: rtl/idata_mem.sv
module idata_mem
    import idata_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int REGS_PER_BANK = 8,
    parameter int BIT_BASE      = 32,
    parameter int BANK_W        = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr,
    input  logic [1:0]        mode,
    input  logic [AW-1:0]     addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              rvalid,
    output logic              sfr_req,
    output logic              sfr_wr,
    output logic [AW-1:0]     sfr_addr,
    output logic [DW-1:0]     sfr_wdata,
    input  logic [DW-1:0]     sfr_rdata
);
    route_t        route;
    logic          is_sfr;
    logic          ram_we;
    logic [DW-1:0] ram_rbyte;
    logic [DW-1:0] cur;
    logic [DW-1:0] wbyte;
    logic [DW-1:0] rfmt;
    logic          rd_req;

    idata_route #(
        .NUM_BANKS    (NUM_BANKS),
        .REGS_PER_BANK(REGS_PER_BANK),
        .BIT_BASE     (BIT_BASE)
    ) u_route (
        .mode    (mode),
        .addr    (addr),
        .bank_sel(bank_sel),
        .route   (route)
    );

    assign is_sfr = (route.tgt == TGT_SFR);
    assign ram_we = req && wr && !is_sfr;
    assign cur    = is_sfr ? sfr_rdata : ram_rbyte;
    assign rd_req = req && !wr;

    idata_store u_store (
        .clk   (clk),
        .we    (ram_we),
        .sel_hi(route.tgt == TGT_HIGH),
        .idx   (route.idx),
        .wbyte (wbyte),
        .rbyte (ram_rbyte)
    );

    idata_bitops u_bits (
        .route(route),
        .wdata(wdata),
        .cur  (cur),
        .wbyte(wbyte),
        .rfmt (rfmt)
    );

    assign sfr_req   = req && is_sfr;
    assign sfr_wr    = sfr_req && wr;
    assign sfr_addr  = route.sfr_addr;
    assign sfr_wdata = wbyte;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_req;
            if (rd_req)
                rdata <= rfmt;
        end
    end

endmodule

// File: rtl/idata_mem_chk.sv
module idata_mem_chk
    import idata_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic              wr,
    input logic [1:0]        mode,
    input logic [AW-1:0]     addr,
    input logic [BANK_W-1:0] bank_sel,
    input logic [DW-1:0]     wdata,
    input logic [DW-1:0]     rdata,
    input logic              rvalid,
    input logic              sfr_req,
    input logic              sfr_wr,
    input logic [AW-1:0]     sfr_addr,
    input logic [DW-1:0]     sfr_wdata,
    input logic [DW-1:0]     sfr_rdata
);
    p_sfr_upper_only_r2: assert property (@(posedge clk) disable iff (rst)
        sfr_req |-> (req && addr[AW-1] && (mode == 2'b00 || mode == 2'b10)));

    p_indirect_no_sfr_r3: assert property (@(posedge clk) disable iff (rst)
        (req && mode == 2'b01) |-> !sfr_req);

    p_bit_read_padded_r6: assert property (@(posedge clk) disable iff (rst)
        (req && !wr && mode == 2'b10) |=> (rvalid && rdata[DW-1:1] == '0));

    p_sfr_bit_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        (sfr_req && mode == 2'b10) |-> (sfr_addr[POS_W-1:0] == '0));

    p_sfr_bit_single_r7: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && mode == 2'b10) |-> ($countones(sfr_wdata ^ sfr_rdata) <= 1));

    p_rvalid_follows_read_r8: assert property (@(posedge clk) disable iff (rst)
        (req && !wr) |=> rvalid);

    p_rvalid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !(req && !wr) |=> !rvalid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req |-> (!sfr_req && !sfr_wr));

endmodule

bind idata_mem idata_mem_chk #(.BANK_W(BANK_W)) u_chk (.*);

// File: tb/sim_idata_mem.sv
module sim_idata_mem;
    logic       clk = 1'b0;
    logic       rst;
    logic       req, wr;
    logic [1:0] mode, bank_sel;
    logic [7:0] addr, wdata, rdata, sfr_addr, sfr_wdata, sfr_rdata;
    logic       rvalid, sfr_req, sfr_wr;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [7:0] ref_lo  [128];
    logic [7:0] ref_hi  [128];
    logic [7:0] ref_sfr [128];
    logic [7:0] sfr_mem [128];

    always #10 clk = ~clk;

    idata_mem u0 (
        .clk(clk), .rst(rst), .req(req), .wr(wr), .mode(mode), .addr(addr),
        .bank_sel(bank_sel), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .sfr_req(sfr_req), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    assign sfr_rdata = sfr_mem[sfr_addr[6:0]];
    always @(posedge clk)
        if (sfr_req && sfr_wr) sfr_mem[sfr_addr[6:0]] <= sfr_wdata;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] m, input logic w, input logic [7:0] a,
                          input logic [7:0] d, input logic [1:0] bk, output logic [7:0] rd);
        @(negedge clk);
        req = 1'b1; wr = w; mode = m; addr = a; wdata = d; bank_sel = bk;
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
        rd = rdata;
        if (!w) check("R8 rvalid", {7'b0, rvalid}, 8'h01);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        for (int i = 0; i < 128; i++) begin
            sfr_mem[i] = 8'(i * 3);
            ref_sfr[i] = 8'(i * 3);
        end
        rst = 1'b1; req = 0; wr = 0; mode = 0; addr = 0; wdata = 0; bank_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset rvalid", {7'b0, rvalid}, 8'h00);
        check("R8 reset rdata", rdata, 8'h00);
        rst = 1'b0;

        // R1: lower half, indirect write / direct read, then the reverse
        for (int a = 0; a < 128; a++) begin
            ref_lo[a] = 8'(a * 7 + 3);
            access(2'b01, 1, 8'(a), ref_lo[a], 0, r);
        end
        for (int a = 0; a < 128; a++) begin
            access(2'b00, 0, 8'(a), 0, 0, r);
            check("R1 direct read", r, ref_lo[a]);
        end
        for (int a = 0; a < 128; a += 5) begin
            ref_lo[a] = 8'(a) ^ 8'h5A;
            access(2'b00, 1, 8'(a), ref_lo[a], 0, r);
        end
        for (int a = 0; a < 128; a++) begin
            access(2'b01, 0, 8'(a), 0, 0, r);
            check("R1 indirect read", r, ref_lo[a]);
        end

        // R3 / R2: upper half, indirect RAM versus SFR port
        for (int a = 0; a < 128; a++) begin
            ref_hi[a] = 8'(a * 13 + 1);
            access(2'b01, 1, 8'(a + 128), ref_hi[a], 0, r);
        end
        for (int a = 0; a < 128; a += 2) begin
            ref_sfr[a] = ~8'(a);
            access(2'b00, 1, 8'(a + 128), ref_sfr[a], 0, r);
        end
        @(negedge clk);
        for (int a = 0; a < 128; a++) check("R2 sfr store", sfr_mem[a], ref_sfr[a]);
        for (int a = 0; a < 128; a++) begin
            access(2'b01, 0, 8'(a + 128), 0, 0, r);
            check("R3 upper ram", r, ref_hi[a]);
        end
        for (int a = 0; a < 128; a += 3) begin
            access(2'b00, 0, 8'(a + 128), 0, 0, r);
            check("R2 sfr read", r, ref_sfr[a]);
        end
        for (int a = 0; a < 128; a += 9) begin
            access(2'b00, 0, 8'(a), 0, 0, r);
            check("R3 lower intact", r, ref_lo[a]);
        end

        // R4: banked registers
        for (int b = 0; b < 4; b++)
            for (int n = 0; n < 8; n++) begin
                ref_lo[b * 8 + n] = 8'((b << 4) | n) ^ 8'hA0;
                access(2'b11, 1, 8'(n), ref_lo[b * 8 + n], 2'(b), r);
            end
        for (int a = 0; a < 32; a++) begin
            access(2'b00, 0, 8'(a), 0, 0, r);
            check("R4 bank via direct", r, ref_lo[a]);
        end
        for (int b = 0; b < 4; b++)
            for (int n = 0; n < 8; n++) begin
                access(2'b11, 0, 8'(n | 8'hF8), 0, 2'(b), r);
                check("R4 bank via reg", r, ref_lo[b * 8 + n]);
            end

        // R5 / R6: bit area in RAM
        for (int a = 32; a < 48; a++) begin
            ref_lo[a] = (a & 1) ? 8'hFF : 8'h00;
            access(2'b00, 1, 8'(a), ref_lo[a], 0, r);
        end
        for (int b = 0; b < 128; b++) begin
            logic v;
            v = 1'(((b * 5) >> 2) & 1);
            ref_lo[32 + b / 8][b % 8] = v;
            access(2'b10, 1, 8'(b), {7'h7F, v}, 0, r);
        end
        for (int a = 0; a < 128; a++) begin
            access(2'b00, 0, 8'(a), 0, 0, r);
            check("R5 byte after bit writes", r, ref_lo[a]);
        end
        for (int b = 0; b < 128; b++) begin
            access(2'b10, 0, 8'(b), 0, 0, r);
            check("R6 bit read", r, {7'b0, ref_lo[32 + b / 8][b % 8]});
        end

        // R7: bit access to SFR bytes
        for (int b = 128; b < 256; b += 3) begin
            logic v;
            v = 1'(~(b >> 1) & 1);
            ref_sfr[(b & 8'hF8) - 128][b & 7] = v;
            access(2'b10, 1, 8'(b), {7'b0, v}, 0, r);
        end
        @(negedge clk);
        for (int a = 0; a < 128; a++) check("R7 sfr after bit writes", sfr_mem[a], ref_sfr[a]);
        for (int b = 128; b < 256; b += 5) begin
            access(2'b10, 0, 8'(b), 0, 0, r);
            check("R7 sfr bit read", r, {7'b0, ref_sfr[(b & 8'hF8) - 128][b & 7]});
        end

        // R9: write strobes with req low
        @(negedge clk);
        req = 0; wr = 1; mode = 2'b00; addr = 8'h10; wdata = ~ref_lo[16];
        #1 check("R9 sfr_req idle", {7'b0, sfr_req}, 8'h00);
        @(negedge clk);
        check("R8 rvalid idle", {7'b0, rvalid}, 8'h00);
        addr = 8'h90; wdata = ~ref_sfr[16]; mode = 2'b00;
        #1 check("R9 sfr_wr idle", {7'b0, sfr_wr}, 8'h00);
        @(negedge clk);
        mode = 2'b01; addr = 8'h90; wdata = ~ref_hi[16];
        @(negedge clk);
        wr = 0;
        check("R9 sfr untouched", sfr_mem[16], ref_sfr[16]);
        access(2'b00, 0, 8'h10, 0, 0, r);
        check("R9 lower untouched", r, ref_lo[16]);
        access(2'b01, 0, 8'h90, 0, 0, r);
        check("R9 upper untouched", r, ref_hi[16]);

        finish_run();
    end

endmodule